// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a physical frame number. It walks four levels of translation tables held in memory. A requester hands over a virtual address together with the frame number of the top-level table, using a valid/ready handshake. The walker then issues one read per level on a simple memory port. Each read fetches a single 8-byte table entry. The entry either names the next table or, at the last level, the final frame.

Pages are 4 KB. The low 12 address bits therefore pass straight into the physical address. The 36 bits above them form four 9-bit indexes, and the most significant index is consumed first. If any entry on the way has its present bit clear, the walk stops at once. The walker then reports a fault and the level at which it stopped. The block holds one walk at a time and lowers its ready line until the result has been presented.

Top module: `ptw_walker`

## Requirements
- R1: The walker accepts a request on a cycle where req_valid and req_ready are both high. req_ready is high whenever no walk is in progress, and it stays low from the cycle after acceptance until the result pulse.
- R2: The virtual address is split as follows: bits [47:39] index the level-0 table, [38:30] level 1, [29:21] level 2, [20:12] level 3. Bits [11:0] are the page offset.
- R3: The read address at level k is (table frame × 4096) + index_k × 8. The level-0 table frame is req_root. The level k+1 table frame is bits [63:12] of the present entry read at level k.
- R4: A memory read holds mem_req_valid and mem_req_addr steady until mem_req_ready is seen high. The next read is not issued before the response to the current one, so a walk makes exactly one read per level it reaches.
- R5: A mem_rsp_valid strobe that arrives while no read is outstanding is ignored. It neither changes the walk nor produces a result.
- R6: Entry layout: bit 0 is present, bit 1 writable, bit 2 user-accessible, bit 3 dirty, and bits [63:12] hold the frame number. Bits [11:4] are ignored.
- R7: When all four entries are present, the result has rsp_fault=0 and rsp_level=3. rsp_pfn equals bits [63:12] of the last entry. rsp_perm is {dirty, user, writable} of that entry (bit 2 down to bit 0). rsp_paddr is {rsp_pfn, va[11:0]}.
- R8: An entry with present clear at level k (0 = first read) ends the walk with no further reads. The result has rsp_fault=1 and rsp_level=k, with rsp_pfn, rsp_perm and rsp_paddr all zero.
- R9: rsp_valid is a single-cycle pulse. The result outputs keep their values after the pulse, and req_ready is high in the cycle that follows it.
- R10: After reset, req_ready is 1 while mem_req_valid and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 48 | Virtual address to translate |
| req_root | input | 52 | Frame number of the top-level table |
| mem_req_valid | output | 1 | Table entry read requested |
| mem_req_ready | input | 1 | Memory takes the read this cycle |
| mem_req_addr | output | 64 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 64 | Table entry returned by memory |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Walk stopped on a non-present entry |
| rsp_level | output | 2 | Level of the last entry read |
| rsp_pfn | output | 52 | Translated frame number |
| rsp_perm | output | 3 | Leaf {dirty, user, writable} |
| rsp_paddr | output | 64 | Frame number joined with the page offset |

## Verification
The assertions watch several properties on every cycle. They check that no second request is taken mid-walk and that a stalled read keeps its address. They check that entry addresses stay 8-byte aligned and that the result is a one-cycle pulse. They also check that the number of reads in a walk equals the reported level plus one, that a good result always ends at level 3, and that a fault result carries zeroed data.

Several behaviours can only be shown by the bench's scenarios, using tables it builds from the address split and entry layout. These are whether each read lands at the right index of the right table, whether the leaf frame, permissions and offset reach the result, and whether stray strobes are ignored. The scenarios cover latency and stall patterns and a fault at each level.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_DONE  = 2'd3
   } walk_st_e;

endpackage

// File: rtl/walk_index_sel.sv
module walk_index_sel #(
   parameter  int VA_W   = 48,
   parameter  int OFF_W  = 12,
   parameter  int IDX_W  = 9,
   parameter  int LEVELS = 4,
   localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [VA_W-1:0]  va,
   input  logic [LVL_W-1:0] lvl,
   output logic [IDX_W-1:0] idx
);

   if (OFF_W + LEVELS * IDX_W != VA_W) begin : g_bad_split
      $error("walk_index_sel: offset plus level indexes must cover the address");
   end

   logic [IDX_W-1:0] idx_arr [LEVELS];

   // level 0 takes the most significant slice
   for (genvar g = 0; g < LEVELS; g++) begin : g_slice
      assign idx_arr[g] = va[VA_W-1-g*IDX_W -: IDX_W];
   end

   assign idx = idx_arr[lvl];

   logic unused_offset;
   assign unused_offset = ^va[OFF_W-1:0];

endmodule

// File: rtl/walk_addr_gen.sv
module walk_addr_gen #(
   parameter  int FRAME_W     = 52,
   parameter  int OFF_W       = 12,
   parameter  int IDX_W       = 9,
   parameter  int ENTRY_BYTES = 8,
   localparam int ADDR_W      = FRAME_W + OFF_W,
   localparam int ESH         = $clog2(ENTRY_BYTES)
) (
   input  logic [FRAME_W-1:0] base,
   input  logic [IDX_W-1:0]   idx,
   output logic [ADDR_W-1:0]  addr
);

   if ((1 << ESH) == ENTRY_BYTES && IDX_W + ESH == OFF_W) begin : g_concat
      // table fills the page exactly: address is a plain bit join
      assign addr = {base, idx, {ESH{1'b0}}};
   end else begin : g_sum
      assign addr = {base, {OFF_W{1'b0}}} + ADDR_W'(idx) * ADDR_W'(ENTRY_BYTES);
   end

endmodule

// File: rtl/walk_entry_dec.sv
module walk_entry_dec #(
   parameter  int ENT_W    = 64,
   parameter  int FRAME_W  = 52,
   parameter  int B_PRES   = 0,
   parameter  int B_WR     = 1,
   parameter  int B_USR    = 2,
   parameter  int B_DIRTY  = 3,
   localparam int FRAME_LO = ENT_W - FRAME_W
) (
   input  logic [ENT_W-1:0]   entry,
   output logic               present,
   output logic               writable,
   output logic               user,
   output logic               dirty,
   output logic [FRAME_W-1:0] frame
);

   if (B_PRES >= FRAME_LO || B_WR >= FRAME_LO || B_USR >= FRAME_LO || B_DIRTY >= FRAME_LO)
   begin : g_bad_flags
      $error("walk_entry_dec: flag bits must sit below the frame field");
   end

   assign present  = entry[B_PRES];
   assign writable = entry[B_WR];
   assign user     = entry[B_USR];
   assign dirty    = entry[B_DIRTY];
   assign frame    = entry[ENT_W-1:FRAME_LO];

   logic unused_low;
   assign unused_low = ^entry[FRAME_LO-1:0];

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
   import ptw_pkg::*;
#(
   parameter  int VA_W    = 48,
   parameter  int OFF_W   = 12,
   parameter  int FRAME_W = 52,
   parameter  int LEVELS  = 4,
   localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int ADDR_W  = FRAME_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [FRAME_W-1:0] req_root,
   output logic [VA_W-1:0]    va_q,
   output logic [LVL_W-1:0]   lvl_q,
   output logic [FRAME_W-1:0] base_q,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   input  logic               mem_rsp_valid,
   input  logic               ent_present,
   input  logic               ent_writable,
   input  logic               ent_user,
   input  logic               ent_dirty,
   input  logic [FRAME_W-1:0] ent_frame,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [LVL_W-1:0]   rsp_level,
   output logic [FRAME_W-1:0] rsp_pfn,
   output logic [2:0]         rsp_perm,
   output logic [ADDR_W-1:0]  rsp_paddr
);

   localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

   walk_st_e st_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         va_q      <= '0;
         lvl_q     <= '0;
         base_q    <= '0;
         rsp_fault <= 1'b0;
         rsp_level <= '0;
         rsp_pfn   <= '0;
         rsp_perm  <= '0;
         rsp_paddr <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  base_q <= req_root;
                  lvl_q  <= '0;
                  st_q   <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) st_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!ent_present) begin
                     rsp_fault <= 1'b1;
                     rsp_level <= lvl_q;
                     rsp_pfn   <= '0;
                     rsp_perm  <= '0;
                     rsp_paddr <= '0;
                     st_q      <= ST_DONE;
                  end else if (lvl_q == LAST_LVL) begin
                     rsp_fault <= 1'b0;
                     rsp_level <= lvl_q;
                     rsp_pfn   <= ent_frame;
                     rsp_perm  <= {ent_dirty, ent_user, ent_writable};
                     rsp_paddr <= {ent_frame, va_q[OFF_W-1:0]};
                     st_q      <= ST_DONE;
                  end else begin
                     base_q <= ent_frame;
                     lvl_q  <= lvl_q + 1'b1;
                     st_q   <= ST_ISSUE;
                  end
               end
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_ISSUE);
   assign rsp_valid     = (st_q == ST_DONE);

   AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready); // R1
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> (!rsp_valid && req_ready)); // R9
   AST_GOOD_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fault) |-> (rsp_level == LAST_LVL)); // R7
   AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault) |-> (rsp_pfn == '0 && rsp_perm == '0 && rsp_paddr == '0)); // R8
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (req_ready && !req_valid) |=> $stable(rsp_pfn) && $stable(rsp_fault)); // R9

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
   parameter  int VA_W        = 48,
   parameter  int OFF_W       = 12,
   parameter  int IDX_W       = 9,
   parameter  int LEVELS      = 4,
   parameter  int FRAME_W     = 52,
   parameter  int ENT_W       = 64,
   parameter  int ENTRY_BYTES = 8,
   localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int ADDR_W      = FRAME_W + OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_vaddr,
   input  logic [FRAME_W-1:0] req_root,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [ADDR_W-1:0]  mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENT_W-1:0]   mem_rsp_data,
   output logic               rsp_valid,
   output logic               rsp_fault,
   output logic [LVL_W-1:0]   rsp_level,
   output logic [FRAME_W-1:0] rsp_pfn,
   output logic [2:0]         rsp_perm,
   output logic [ADDR_W-1:0]  rsp_paddr
);

   localparam int ESH = $clog2(ENTRY_BYTES);

   if (ENT_W - OFF_W != FRAME_W) begin : g_bad_entry
      $error("ptw_walker: entry frame field must equal the frame width");
   end
   if (ENT_W != ENTRY_BYTES * 8) begin : g_bad_bytes
      $error("ptw_walker: entry width must match the entry byte size");
   end

   logic [VA_W-1:0]    va_q;
   logic [LVL_W-1:0]   lvl_q;
   logic [FRAME_W-1:0] base_q;
   logic [IDX_W-1:0]   cur_idx;
   logic               ent_present;
   logic               ent_writable;
   logic               ent_user;
   logic               ent_dirty;
   logic [FRAME_W-1:0] ent_frame;

   walk_index_sel #(
      .VA_W   (VA_W),
      .OFF_W  (OFF_W),
      .IDX_W  (IDX_W),
      .LEVELS (LEVELS)
   ) u_idx (
      .va  (va_q),
      .lvl (lvl_q),
      .idx (cur_idx)
   );

   walk_addr_gen #(
      .FRAME_W     (FRAME_W),
      .OFF_W       (OFF_W),
      .IDX_W       (IDX_W),
      .ENTRY_BYTES (ENTRY_BYTES)
   ) u_addr (
      .base (base_q),
      .idx  (cur_idx),
      .addr (mem_req_addr)
   );

   walk_entry_dec #(
      .ENT_W   (ENT_W),
      .FRAME_W (FRAME_W)
   ) u_dec (
      .entry    (mem_rsp_data),
      .present  (ent_present),
      .writable (ent_writable),
      .user     (ent_user),
      .dirty    (ent_dirty),
      .frame    (ent_frame)
   );

   walk_ctrl #(
      .VA_W    (VA_W),
      .OFF_W   (OFF_W),
      .FRAME_W (FRAME_W),
      .LEVELS  (LEVELS)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .req_root      (req_root),
      .va_q          (va_q),
      .lvl_q         (lvl_q),
      .base_q        (base_q),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_rsp_valid (mem_rsp_valid),
      .ent_present   (ent_present),
      .ent_writable  (ent_writable),
      .ent_user      (ent_user),
      .ent_dirty     (ent_dirty),
      .ent_frame     (ent_frame),
      .rsp_valid     (rsp_valid),
      .rsp_fault     (rsp_fault),
      .rsp_level     (rsp_level),
      .rsp_pfn       (rsp_pfn),
      .rsp_perm      (rsp_perm),
      .rsp_paddr     (rsp_paddr)
   );

   // reads since the last accepted request, for the per-walk read count check
   logic [LVL_W:0] chk_reads_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_reads_q <= '0;
      end else if (req_valid && req_ready) begin
         chk_reads_q <= '0;
      end else if (mem_req_valid && mem_req_ready) begin
         chk_reads_q <= chk_reads_q + 1'b1;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4
   AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> (mem_req_addr[ESH-1:0] == '0)); // R3
   AST_READS_PER_WALK: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (chk_reads_q == {1'b0, rsp_level} + 1'b1)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_req_valid); // R1

endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;

   localparam int NV = 6;

   localparam logic [47:0] V_VA [NV] = '{
      48'h0000_0000_0123, 48'hFFFF_FFFF_FABC, 48'h1234_5678_9ABC,
      48'h8040_2010_0FFF, 48'h7F80_0000_1000, 48'h0000_8000_0001 };
   localparam logic [51:0] V_ROOT [NV] = '{
      52'h0_0000_0000_0010, 52'h0_0000_00AB_C000, 52'h0_0000_0000_0000,
      52'h0_0001_0002_0003, 52'h0_0000_0FED_0000, 52'h8_0000_0000_0001 };
   localparam int V_FLT [NV] = '{ 4, 4, 0, 1, 2, 3 };
   localparam logic [51:0] V_PFN [NV] = '{
      52'h0_0000_0000_0ABC, 52'hF_FFFF_FFFF_FFFF, 52'h1_2345_6789_ABCD,
      52'h0_0000_0000_0001, 52'h0_0000_0000_0002, 52'h0_0000_0000_0003 };
   localparam logic [2:0] V_PERM [NV] = '{ 3'b000, 3'b111, 3'b101, 3'b010, 3'b001, 3'b110 };
   localparam int V_LAT [NV] = '{ 0, 3, 1, 0, 2, 5 };
   localparam bit V_STALL [NV] = '{ 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1 };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [47:0] req_vaddr = '0;
   logic [51:0] req_root = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [63:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [1:0]  rsp_level;
   logic [51:0] rsp_pfn;
   logic [2:0]  rsp_perm;
   logic [63:0] rsp_paddr;

   ptw_walker u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_vaddr     (req_vaddr),
      .req_root      (req_root),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .rsp_valid     (rsp_valid),
      .rsp_fault     (rsp_fault),
      .rsp_level     (rsp_level),
      .rsp_pfn       (rsp_pfn),
      .rsp_perm      (rsp_perm),
      .rsp_paddr     (rsp_paddr)
   );

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;

   // memory model state
   logic [63:0] mem_map [logic [63:0]];
   int          lat = 0;
   bit          stall = 1'b0;
   bit          spur = 1'b0;
   bit          pend = 1'b0;
   int          wcnt = 0;
   int          nreads = 0;
   int          bad_reads = 0;
   int          ncyc = 0;
   logic [63:0] rd_addr = '0;

   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 64'h0;
      if (!rst_n) begin
         pend = 1'b0;
         mem_req_ready = 1'b0;
      end else begin
         if (pend) begin
            if (wcnt >= lat) begin
               mem_rsp_valid = 1'b1;
               if (mem_map.exists(rd_addr)) mem_rsp_data = mem_map[rd_addr];
               else bad_reads++;
               pend = 1'b0;
            end else begin
               wcnt++;
            end
         end else if (spur) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 64'hFFFF_FFFF_FFFF_FFFF;
         end
         ncyc++;
         mem_req_ready = stall ? ncyc[1] : 1'b1;
         if (mem_req_valid && mem_req_ready) begin
            pend    = 1'b1;
            wcnt    = 0;
            rd_addr = mem_req_addr;
            nreads++;
         end
      end
   end

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // tables follow R2, R3 and R6
   task automatic build(input logic [47:0] va, input logic [51:0] root, input int flt,
                        input logic [51:0] pfn, input logic [2:0] perm);
      logic [51:0] base;
      logic [51:0] nxt;
      logic [8:0]  ix;
      logic [63:0] a;
      mem_map.delete();
      base = root;
      for (int k = 0; k < 4; k++) begin
         ix = va[47-9*k -: 9];
         a  = {base, ix, 3'b000};
         if (k == flt) begin
            mem_map[a] = {52'hF_EDCB_A987_6543, 8'hA5, 4'b1110};
            break;
         end else if (k == 3) begin
            mem_map[a] = {pfn, 8'h00, perm, 1'b1};
         end else begin
            nxt = base + 52'(k * 4097 + 4097);
            mem_map[a] = {nxt, 8'h3C, 4'b0001};
            base = nxt;
         end
      end
   endtask

   task automatic start_walk(input logic [47:0] va, input logic [51:0] root);
      int guard;
      guard = 0;
      @(negedge clk);
      while (!req_ready && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      req_vaddr = va;
      req_root  = root;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp(output bit got);
      int guard;
      guard = 0;
      got = 1'b0;
      while (!rsp_valid && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      got = rsp_valid;
   endtask

   task automatic run_walk(input logic [47:0] va, input logic [51:0] root, input int flt,
                           input logic [51:0] pfn, input logic [2:0] perm, input string tag);
      int  r0;
      int  b0;
      bit  got;
      int  exp_reads;
      build(va, root, flt, pfn, perm);
      r0 = nreads;
      b0 = bad_reads;
      start_walk(va, root);
      wait_rsp(got);
      chk({tag, " R7 result pulse seen"}, 64'(got), 64'd1);
      exp_reads = (flt < 4) ? flt + 1 : 4;
      chk({tag, " R3 read addresses from table chain (R2 index split)"}, 64'(bad_reads - b0), 64'd0);
      chk({tag, " R4 one read per level"}, 64'(nreads - r0), 64'(exp_reads));
      if (flt < 4) begin
         chk({tag, " R8 fault flag"}, 64'(rsp_fault), 64'd1);
         chk({tag, " R8 fault level"}, 64'(rsp_level), 64'(flt));
         chk({tag, " R8 zero frame"}, 64'(rsp_pfn), 64'd0);
         chk({tag, " R8 zero perm and address"}, {rsp_paddr[60:0], rsp_perm}, 64'd0);
      end else begin
         chk({tag, " R7 no fault"}, 64'(rsp_fault), 64'd0);
         chk({tag, " R7 level"}, 64'(rsp_level), 64'd3);
         chk({tag, " R7 frame"}, 64'(rsp_pfn), 64'(pfn));
         chk({tag, " R7 R6 perm"}, 64'(rsp_perm), 64'(perm));
         chk({tag, " R7 paddr"}, rsp_paddr, {pfn, va[11:0]});
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      bit got;
      int busy_bad;
      int spur_bad;
      logic [51:0] held;

      repeat (5) @(negedge clk);
      chk("R10 reset ready", 64'(req_ready), 64'd1);
      chk("R10 reset no read", 64'(mem_req_valid), 64'd0);
      chk("R10 reset no result", 64'(rsp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 ready after release", 64'(req_ready), 64'd1);

      // vector table
      for (int v = 0; v < NV; v++) begin
         lat   = V_LAT[v];
         stall = V_STALL[v];
         run_walk(V_VA[v], V_ROOT[v], V_FLT[v], V_PFN[v], V_PERM[v], $sformatf("vec%0d", v));
      end

      // R1 and R9: busy window, single pulse, held result
      lat = 4;
      stall = 1'b0;
      build(48'h0ABC_DEF0_1234, 52'h0_0000_0005_5000, 4, 52'h0_0000_0007_7777, 3'b011);
      start_walk(48'h0ABC_DEF0_1234, 52'h0_0000_0005_5000);
      busy_bad = 0;
      for (int i = 0; i < 8; i++) begin
         if (req_ready) busy_bad++;
         @(negedge clk);
      end
      chk("R1 ready low during walk", 64'(busy_bad), 64'd0);
      wait_rsp(got);
      chk("R9 pulse present", 64'(got), 64'd1);
      held = rsp_pfn;
      chk("R7 busy walk frame", 64'(held), 64'h7_7777);
      @(negedge clk);
      chk("R9 pulse one cycle", 64'(rsp_valid), 64'd0);
      chk("R9 ready after pulse", 64'(req_ready), 64'd1);
      chk("R9 frame held", 64'(rsp_pfn), 64'(held));

      // R5: stray strobes while idle
      lat = 0;
      spur = 1'b1;
      spur_bad = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (rsp_valid || !req_ready || mem_req_valid) spur_bad++;
      end
      chk("R5 idle strobes ignored", 64'(spur_bad), 64'd0);
      chk("R5 frame untouched by strobes", 64'(rsp_pfn), 64'(held));

      // R5: stray strobes during issue stalls
      stall = 1'b1;
      run_walk(48'h5555_AAAA_5123, 52'h0_0000_0000_0777, 4, 52'h0_0000_0001_2345, 3'b100, "stray");
      spur = 1'b0;

      // back-to-back walks, fault at level 0 then success
      stall = 1'b0;
      run_walk(48'hFFFF_0000_FFFF, 52'h0_0000_0000_0042, 0, 52'h0, 3'b000, "b2b0");
      run_walk(48'h0000_FFFF_0000, 52'h0_0000_0000_0042, 4, 52'h0_0000_0000_0BEE, 3'b111, "b2b1");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule